// File: doc/BRIEF.md
# Prioritised Command Collector with Pre-emptible Transfer Side

This block sits between a slow operator-style input port and a small storage subsystem. It takes commands from two state machines of different priority and gathers their operands over one shared request/ready handshake. The foreground machine is the high-priority side. It serves single-address reads and address-plus-data writes. The background machine is the low-priority side. It serves copy and swap, and each of these needs a source address and a destination address. The block drives no storage of its own. It holds the captured operands in four registers, and when a command's operands are complete it raises exactly one one-cycle start strobe.

The background side may only advance while a permit signal is high. That signal is the enable input exclusive-ORed with the foreground busy flag. A read or write can therefore cut in while a copy or swap is still waiting for an operand. The background side then parks in idle but stays busy, and it keeps two flags: the command kind and whether the first address has already been taken. When the foreground strobe fires, the foreground hands control back. The background side then resumes from the step it had reached and does not start over. Pulling the enable input low clears every operand register and both machines.

Top module: `prio_xfer_ctrl`

## Requirements
- R1: Handshake. A request is raised only after ready was seen low. A value on `din_i` is stored in the cycle in which ready is high while a request is up. The request then drops, and the next request waits for ready to return low.
- R2: A rising edge on `go_i` with `xfer_i`=0 and `alt_i`=0 starts a read. One address is loaded into `addr_o`, and `rd_start_o` fires one cycle after ready is released.
- R3: A go edge with `xfer_i`=0 and `alt_i`=1 starts a write. The address is loaded into `addr_o`, then the data word into `data_o`, and `wr_start_o` fires after the second release.
- R4: A go edge with `xfer_i`=1 activates the background side. It loads `src_o` and then `dst_o`, and fires `cp_start_o` when `alt_i` was 0 or `sw_start_o` when `alt_i` was 1.
- R5: `hp_busy_o` is high from the acceptance of a read or write until its strobe. `allow_o` equals `en_i` XOR `hp_busy_o`.
- R6: A read or write accepted while the background side waits for an operand sends it to idle with `lp_busy_o` still high. After the foreground strobe it resumes with its stored command kind. If the source address was already taken, the next operand it collects is the destination.
- R7: The four start strobes are one-hot-or-zero and last exactly one cycle.
- R8: While `en_i` is low, all four operand registers read 0, both busy flags are 0, and no request is raised. A partly collected copy or swap is forgotten.
- R9: A go edge with `xfer_i`=1 while the background side is busy is ignored. The pending command keeps its original kind and operands.
- R10: After reset with `en_i` high, every operand register is 0, no request or strobe is up, both busy flags are 0 and `allow_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; low clears registers and machines |
| go_i | input | 1 | Command start; acted on at its rising edge |
| xfer_i | input | 1 | 0 = read/write, 1 = copy/swap |
| alt_i | input | 1 | 0 = read or copy, 1 = write or swap |
| rdy_i | input | 1 | Operand-ready handshake from the user port |
| din_i | input | W | Operand value from the user port |
| req_o | output | 1 | Operand request to the user port |
| allow_o | output | 1 | Background permit |
| hp_busy_o | output | 1 | Foreground command in progress |
| lp_busy_o | output | 1 | Background command pending or in progress |
| addr_o | output | W | Foreground address register |
| data_o | output | W | Foreground data register |
| src_o | output | W | Background source address register |
| dst_o | output | W | Background destination address register |
| rd_start_o | output | 1 | One-cycle read strobe |
| wr_start_o | output | 1 | One-cycle write strobe |
| cp_start_o | output | 1 | One-cycle copy strobe |
| sw_start_o | output | 1 | One-cycle swap strobe |

## Verification
The bench interrupts a swap after its source address is taken and a copy before any operand is taken. A design that lost its progress flag would store the next value as the source again. A design that lost the kind flag would fire the wrong strobe. Both faults show up as a scoreboard mismatch on `src_o`, `dst_o` or the strobe kind. The bench also drops enable partway through a copy and then runs a fresh one, which catches stale progress left over from the aborted command. It also sends a second copy/swap go edge during a pending swap, and a design that accepted it would change the kind. Finally, it checks that the permit falls while a read is collected and that the background stays busy while parked.

// File: rtl/prio_xfer_pkg.sv
package prio_xfer_pkg;
  typedef enum logic [2:0] {
    H_IDLE, H_WAIT, H_A_REQ, H_A_REL, H_D_REQ, H_D_REL
  } hp_state_t;

  typedef enum logic [2:0] {
    L_IDLE, L_ARM, L_A1_REQ, L_A1_REL, L_A2_REQ, L_A2_REL
  } lp_state_t;

  localparam int unsigned NREG   = 4;
  localparam int unsigned IX_ADR = 0;
  localparam int unsigned IX_DAT = 1;
  localparam int unsigned IX_SRC = 2;
  localparam int unsigned IX_DST = 3;
endpackage

// File: rtl/prio_reg_bank.sv
module prio_reg_bank #(
  parameter int unsigned W = 4,
  parameter int unsigned N = 4
) (
  input  logic                clk,
  input  logic                clr,
  input  logic [N-1:0]        ld,
  input  logic [W-1:0]        d,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (clr)        q[i] <= '0;
      else if (ld[i]) q[i] <= d;
    end
  end
endmodule

// File: rtl/prio_hp_fsm.sv
module prio_hp_fsm
  import prio_xfer_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic go_i,
  input  logic xfer_i,
  input  logic alt_i,
  input  logic rdy_i,
  input  logic lp_busy_i,
  output logic req_o,
  output logic busy_o,
  output logic ld_addr_o,
  output logic ld_data_o,
  output logic rd_o,
  output logic wr_o,
  output logic kick_o,
  output logic kick_swap_o
);
  hp_state_t st;
  logic go_q, is_wr;

  assign req_o     = (st == H_A_REQ) || (st == H_D_REQ);
  assign ld_addr_o = (st == H_A_REQ) && rdy_i;
  assign ld_data_o = (st == H_D_REQ) && rdy_i;

  always_ff @(posedge clk) begin
    if (clr) begin
      st          <= H_IDLE;
      go_q        <= 1'b0;
      is_wr       <= 1'b0;
      busy_o      <= 1'b0;
      rd_o        <= 1'b0;
      wr_o        <= 1'b0;
      kick_o      <= 1'b0;
      kick_swap_o <= 1'b0;
    end else begin
      go_q   <= go_i;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      kick_o <= 1'b0;
      unique case (st)
        H_IDLE: if (go_i && !go_q) begin
          if (!xfer_i) begin
            busy_o <= 1'b1;
            is_wr  <= alt_i;
            st     <= H_WAIT;
          end else if (!lp_busy_i) begin
            kick_o      <= 1'b1;
            kick_swap_o <= alt_i;
          end
        end
        H_WAIT:  if (!rdy_i) st <= H_A_REQ;
        H_A_REQ: if (rdy_i)  st <= H_A_REL;
        H_A_REL: if (!rdy_i) begin
          if (is_wr) st <= H_D_REQ;
          else begin
            st     <= H_IDLE;
            busy_o <= 1'b0;
            rd_o   <= 1'b1;
            kick_o <= lp_busy_i;
          end
        end
        H_D_REQ: if (rdy_i)  st <= H_D_REL;
        H_D_REL: if (!rdy_i) begin
          st     <= H_IDLE;
          busy_o <= 1'b0;
          wr_o   <= 1'b1;
          kick_o <= lp_busy_i;
        end
        default: st <= H_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_lp_fsm.sv
module prio_lp_fsm
  import prio_xfer_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic kick_i,
  input  logic kick_swap_i,
  input  logic allow_i,
  input  logic rdy_i,
  output logic req_o,
  output logic busy_o,
  output logic ld_src_o,
  output logic ld_dst_o,
  output logic cp_o,
  output logic sw_o
);
  lp_state_t st;
  logic swp, prog;

  assign req_o    = (st == L_A1_REQ) || (st == L_A2_REQ);
  assign ld_src_o = (st == L_A1_REQ) && allow_i && rdy_i;
  assign ld_dst_o = (st == L_A2_REQ) && allow_i && rdy_i;

  always_ff @(posedge clk) begin
    if (clr) begin
      st     <= L_IDLE;
      busy_o <= 1'b0;
      swp    <= 1'b0;
      prog   <= 1'b0;
      cp_o   <= 1'b0;
      sw_o   <= 1'b0;
    end else begin
      cp_o <= 1'b0;
      sw_o <= 1'b0;
      unique case (st)
        L_IDLE: if (kick_i && allow_i) begin
          st     <= L_ARM;
          busy_o <= 1'b1;
          if (!busy_o) begin
            swp  <= kick_swap_i;
            prog <= 1'b0;
          end
        end
        L_ARM: begin
          if (!allow_i)   st <= L_IDLE;
          else if (!rdy_i) st <= prog ? L_A2_REQ : L_A1_REQ;
        end
        L_A1_REQ: begin
          if (!allow_i) st <= L_IDLE;
          else if (rdy_i) begin
            prog <= 1'b1;
            st   <= L_A1_REL;
          end
        end
        L_A1_REL: if (!rdy_i) st <= L_A2_REQ;
        L_A2_REQ: begin
          if (!allow_i)   st <= L_IDLE;
          else if (rdy_i) st <= L_A2_REL;
        end
        L_A2_REL: if (!rdy_i) begin
          st     <= L_IDLE;
          busy_o <= 1'b0;
          prog   <= 1'b0;
          swp    <= 1'b0;
          cp_o   <= !swp;
          sw_o   <= swp;
        end
        default: st <= L_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_xfer_ctrl.sv
module prio_xfer_ctrl
  import prio_xfer_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         go_i,
  input  logic         xfer_i,
  input  logic         alt_i,
  input  logic         rdy_i,
  input  logic [W-1:0] din_i,
  output logic         req_o,
  output logic         allow_o,
  output logic         hp_busy_o,
  output logic         lp_busy_o,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] data_o,
  output logic [W-1:0] src_o,
  output logic [W-1:0] dst_o,
  output logic         rd_start_o,
  output logic         wr_start_o,
  output logic         cp_start_o,
  output logic         sw_start_o
);
  logic clr;
  logic hp_req, lp_req, kick, kick_swap;
  logic [NREG-1:0]        ld;
  logic [NREG-1:0][W-1:0] q;

  assign clr     = rst || !en_i;
  assign allow_o = en_i ^ hp_busy_o;
  assign req_o   = hp_req || lp_req;

  prio_hp_fsm u_hp (
    .clk(clk), .clr(clr), .go_i(go_i), .xfer_i(xfer_i), .alt_i(alt_i),
    .rdy_i(rdy_i), .lp_busy_i(lp_busy_o), .req_o(hp_req), .busy_o(hp_busy_o),
    .ld_addr_o(ld[IX_ADR]), .ld_data_o(ld[IX_DAT]), .rd_o(rd_start_o),
    .wr_o(wr_start_o), .kick_o(kick), .kick_swap_o(kick_swap)
  );

  prio_lp_fsm u_lp (
    .clk(clk), .clr(clr), .kick_i(kick), .kick_swap_i(kick_swap),
    .allow_i(allow_o), .rdy_i(rdy_i), .req_o(lp_req), .busy_o(lp_busy_o),
    .ld_src_o(ld[IX_SRC]), .ld_dst_o(ld[IX_DST]), .cp_o(cp_start_o),
    .sw_o(sw_start_o)
  );

  prio_reg_bank #(.W(W), .N(NREG)) u_regs (
    .clk(clk), .clr(clr), .ld(ld), .d(din_i), .q(q)
  );

  assign addr_o = q[IX_ADR];
  assign data_o = q[IX_DAT];
  assign src_o  = q[IX_SRC];
  assign dst_o  = q[IX_DST];
endmodule

// File: rtl/prio_xfer_ctrl_chk.sv
module prio_xfer_ctrl_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         en_i,
  input logic         rdy_i,
  input logic         req_o,
  input logic         hp_busy_o,
  input logic         lp_busy_o,
  input logic [W-1:0] addr_o,
  input logic [W-1:0] data_o,
  input logic [W-1:0] src_o,
  input logic [W-1:0] dst_o,
  input logic         rd_start_o,
  input logic         wr_start_o,
  input logic         cp_start_o,
  input logic         sw_start_o
);
  logic [3:0] strobes;
  assign strobes = {sw_start_o, cp_start_o, wr_start_o, rd_start_o};

  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

  p_width_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes != 4'b0) |=> (strobes == 4'b0));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (addr_o == '0 && data_o == '0 && src_o == '0 && dst_o == '0
               && !req_o && !hp_busy_o && !lp_busy_o));

  p_req_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> !$past(rdy_i));

  p_busy_end_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && $past(en_i) && $fell(hp_busy_o)) |-> (rd_start_o || wr_start_o));

  p_strobe_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (strobes != 4'b0) |-> !req_o);
endmodule

bind prio_xfer_ctrl prio_xfer_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/prio_xfer_ctrl_test.sv
module prio_xfer_ctrl_test;
  localparam int W = 4;
  localparam time TCLK = 10ns;
  localparam int K_RD = 0, K_WR = 1, K_CP = 2, K_SW = 3;

  logic clk = 0, rst = 1, en = 1, go = 0, xfer = 0, alt = 0, rdy = 0;
  logic [W-1:0] din = '0;
  logic req, allow, hpb, lpb, rds, wrs, cps, sws;
  logic [W-1:0] addr, data, src, dst;

  typedef struct { int k; int a; int b; } exp_t;
  exp_t expq[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] prev_str = '0;

  always #(TCLK/2) clk = ~clk;

  prio_xfer_ctrl #(.W(W)) uut (
    .clk(clk), .rst(rst), .en_i(en), .go_i(go), .xfer_i(xfer), .alt_i(alt),
    .rdy_i(rdy), .din_i(din), .req_o(req), .allow_o(allow),
    .hp_busy_o(hpb), .lp_busy_o(lpb), .addr_o(addr), .data_o(data),
    .src_o(src), .dst_o(dst), .rd_start_o(rds), .wr_start_o(wrs),
    .cp_start_o(cps), .sw_start_o(sws)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    logic [3:0] s;
    s = {sws, cps, wrs, rds};
    if (!rst) begin
      if (prev_str != 4'b0) chk(s == 4'b0, "R7 width", s, 0);
      if (s != 4'b0) begin
        chk($countones(s) == 1, "R7 onehot", s, 1);
        if (expq.size() == 0) chk(0, "R2/R3/R4 unexpected strobe", s, 0);
        else begin
          exp_t e;
          int ka, kb;
          e = expq.pop_front();
          chk(s == (4'b1 << e.k), "R2/R3/R4 strobe kind", s, 1 << e.k);
          ka = (e.k <= K_WR) ? int'(addr) : int'(src);
          kb = (e.k == K_WR) ? int'(data) : (e.k >= K_CP) ? int'(dst) : e.b;
          chk(ka == e.a, "R6 first operand", ka, e.a);
          chk(kb == e.b, "R6 second operand", kb, e.b);
        end
      end
    end
    prev_str = s;
  end

  task automatic push(input int k, input int a, input int b);
    exp_t e;
    e.k = k; e.a = a; e.b = b;
    expq.push_back(e);
  endtask

  task automatic pulse_go(input logic x, input logic a);
    @(negedge clk);
    xfer = x; alt = a; go = 1;
    @(negedge clk);
    go = 0;
  endtask

  task automatic give(input int v);
    int t;
    t = 0;
    while (!req && t < 200) begin @(negedge clk); t++; end
    chk(req, "R1 request seen", req, 1);
    din = v[W-1:0]; rdy = 1;
    t = 0;
    do begin @(negedge clk); t++; end while (req && t < 200);
    chk(!req, "R1 request dropped after ready", req, 0);
    rdy = 0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(addr == 0 && data == 0 && src == 0 && dst == 0, "R10 regs", addr, 0);
    chk(!req && !hpb && !lpb, "R10 idle", {req, hpb, lpb}, 0);
    chk(allow, "R10 allow", allow, 1);

    // R2 read
    push(K_RD, 3, 0);
    pulse_go(0, 0);
    chk(hpb && !allow, "R5 allow low while foreground busy", allow, 0);
    give(3);
    settle();
    chk(!hpb && allow, "R5 allow back after strobe", allow, 1);

    // R3 write
    push(K_WR, 9, 5);
    pulse_go(0, 1);
    give(9); give(5);
    settle();

    // R4 copy and swap
    push(K_CP, 2, 10);
    pulse_go(1, 0);
    give(2); give(10);
    settle();
    push(K_SW, 4, 12);
    pulse_go(1, 1);
    give(4); give(12);
    settle();
    chk(!lpb, "R4 background idle after swap", lpb, 0);

    // R6 swap interrupted after source taken, by a write
    push(K_WR, 2, 14);
    push(K_SW, 5, 11);
    pulse_go(1, 1);
    give(5);
    repeat (2) @(negedge clk);
    pulse_go(0, 1);
    repeat (3) @(negedge clk);
    chk(lpb, "R6 background stays busy when parked", lpb, 1);
    give(2); give(14);
    give(11);
    settle();

    // R6 copy interrupted before any operand, by a read
    push(K_RD, 1, 0);
    push(K_CP, 3, 8);
    pulse_go(1, 0);
    repeat (3) @(negedge clk);
    pulse_go(0, 0);
    repeat (3) @(negedge clk);
    give(1);
    give(3); give(8);
    settle();

    // R9 second copy/swap go ignored while swap pending
    push(K_SW, 10, 6);
    pulse_go(1, 1);
    repeat (3) @(negedge clk);
    pulse_go(1, 0);
    repeat (2) @(negedge clk);
    give(10); give(6);
    settle();

    // R8 enable drop clears everything, aborts partial copy
    pulse_go(1, 0);
    give(7);
    @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(addr == 0 && data == 0 && src == 0 && dst == 0, "R8 regs cleared", src, 0);
    chk(!req && !hpb && !lpb, "R8 machines cleared", {req, hpb, lpb}, 0);
    chk(!allow, "R8 allow low when disabled", allow, 0);
    en = 1;
    @(negedge clk);
    push(K_CP, 13, 15);
    pulse_go(1, 0);
    give(13); give(15);
    settle();

    chk(expq.size() == 0, "R2/R3/R4 all strobes seen", expq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule